// File: doc/BRIEF.md
# Dithered-Period Bridge PWM Modulator

This block turns a signed audio sample into a pair of logic-level drive signals for one bridge-tied speaker that has no output filter. Both legs start each switching period high together. Each leg's high time is set by the sample: a positive sample lengthens the high time of the positive leg and shortens the negative leg's by the same amount. A negative sample does the opposite. The difference of the two pulse widths is the differential drive across the load. With a zero sample both legs carry identical 50% waveforms, so the load sees no net voltage.

The nominal period is a whole number of system clocks, chosen so that each leg switches near 300 kHz (417 clocks of a 125 MHz clock by default). When the spread control is high, a 16-bit LFSR picks a new period length at every period boundary, uniformly within ±30% of nominal. The pulse widths are scaled to the period that was picked, so dithering the period leaves the mean duty unchanged. The sample is taken only at a period boundary. Clearing the run enable lets the current period finish, and then both legs are held low.

Top module: `sspwm_modulator`

## Requirements
- R1: With a zero sample, both legs are high for exactly floor(P/2) clocks of a period of P clocks.
- R2: With the spread control low when a period starts, that period lasts exactly NOM_PERIOD clocks (417 by default).
- R3: For a positive sample s (SAMPLE_W-bit two's complement), with h = floor(P/2) and d = floor(s*h / 2^(SAMPLE_W-1)), the positive leg is high for h+d clocks and the negative leg for h-d clocks.
- R4: A negative sample uses the same rule with d negative, so the negative leg is the wider one.
- R5: Both legs go high in the same clock at the start of every period.
- R6: With the spread control high when a period starts, its length P lies between NOM_PERIOD-SPAN and NOM_PERIOD+SPAN, where SPAN = floor(NOM_PERIOD*SPREAD_PCT/100) (125 by default).
- R7: With the spread control high, the period length changes from one period to another (at least two distinct lengths appear in twenty-four periods).
- R8: Under spread, the pulse widths follow the R3 rule evaluated with the dithered period P.
- R9: Each high time is clamped to between 1 and P-1 clocks, so the most negative sample gives 1 and P-1 clocks.
- R10: A change of the sample in the middle of a period does not alter that period's pulse widths.
- R11: When the run enable falls, the current period completes with its full high times, and then both legs stay low.
- R12: During and after reset, with the run enable low, both legs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Run enable; sampled at period boundaries |
| spread_en | input | 1 | Period dithering enable; sampled at period boundaries |
| sample_in | input | SAMPLE_W | Signed audio sample, captured at period start |
| out_p | output | 1 | Positive bridge leg drive |
| out_n | output | 1 | Negative bridge leg drive |

## Verification
A wrong counter or period register shows up as a period of the wrong length, either fixed or outside the band. The measurement catches this at the next rising edge of the positive leg, within one period. A wrong duty register or a bad scaling result shows as a high-time mismatch in the period that follows the capture. A sample latched at the wrong moment shows as the widths of the injected mid-period value instead of the captured one. A missed stop shows as a pulse during the held-low window that follows the disable.

// File: rtl/sspwm_pkg.sv
package sspwm_pkg;

  // Period for the next switching cycle: nominal, or a uniform pick in the band.
  function automatic int pick_period(int nom, int span, logic [15:0] rnd, logic spread);
    int r;
    r = int'({16'd0, rnd});
    if (!spread) return nom;
    return nom - span + ((r * (2 * span + 1)) >>> 16);
  endfunction

  // High time of one leg, scaled to the period and clamped so no edge is lost.
  function automatic int leg_high(int period, int samp, int sw, logic neg);
    int half;
    int delta;
    int d;
    half  = period / 2;
    delta = (samp * half) >>> (sw - 1);
    d     = neg ? (half - delta) : (half + delta);
    if (d < 1) d = 1;
    if (d > period - 1) d = period - 1;
    return d;
  endfunction

endpackage

// File: rtl/sspwm_dither.sv
module sspwm_dither #(
  parameter int          NOM_PERIOD = 417,
  parameter int          SPAN       = 125,
  parameter int          PW         = 10,
  parameter logic [15:0] SEED       = 16'hACE1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          spread_en,
  output logic [PW-1:0] period_nxt
);
  import sspwm_pkg::*;

  localparam logic [15:0] TAPS = 16'hB400;

  logic [15:0] lfsr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   lfsr_q <= SEED;
    else if (adv) lfsr_q <= {1'b0, lfsr_q[15:1]} ^ (lfsr_q[0] ? TAPS : 16'h0000);
  end

  always_comb period_nxt = PW'(pick_period(NOM_PERIOD, SPAN, lfsr_q, spread_en));

endmodule

// File: rtl/sspwm_duty.sv
module sspwm_duty #(
  parameter int SAMPLE_W = 12,
  parameter int PW       = 10
) (
  input  logic [PW-1:0]             period,
  input  logic signed [SAMPLE_W-1:0] sample,
  output logic [PW-1:0]             duty_p,
  output logic [PW-1:0]             duty_n
);
  import sspwm_pkg::*;

  logic [PW-1:0] duty [2];

  for (genvar gi = 0; gi < 2; gi++) begin : g_leg
    always_comb begin
      duty[gi] = PW'(leg_high(int'({{(32-PW){1'b0}}, period}), int'(sample),
                              SAMPLE_W, (gi == 1)));
    end
  end

  assign duty_p = duty[0];
  assign duty_n = duty[1];

endmodule

// File: rtl/sspwm_timer.sv
module sspwm_timer #(
  parameter int NOM_PERIOD = 417,
  parameter int PW         = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_en,
  input  logic [PW-1:0] period_nxt,
  input  logic [PW-1:0] dp_nxt,
  input  logic [PW-1:0] dn_nxt,
  output logic          out_p,
  output logic          out_n,
  output logic          start_evt,
  output logic          running,
  output logic [PW-1:0] cnt,
  output logic [PW-1:0] period_q,
  output logic [PW-1:0] dp_q,
  output logic [PW-1:0] dn_q
);
  logic boundary;

  assign boundary  = !running || (cnt == period_q - PW'(1));
  assign start_evt = boundary && run_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running  <= 1'b0;
      cnt      <= '0;
      period_q <= PW'(NOM_PERIOD);
      dp_q     <= PW'(NOM_PERIOD / 2);
      dn_q     <= PW'(NOM_PERIOD / 2);
    end else if (boundary) begin
      running <= run_en;
      cnt     <= '0;
      if (run_en) begin
        period_q <= period_nxt;
        dp_q     <= dp_nxt;
        dn_q     <= dn_nxt;
      end
    end else begin
      cnt <= cnt + PW'(1);
    end
  end

  assign out_p = running && (cnt < dp_q);
  assign out_n = running && (cnt < dn_q);

endmodule

// File: rtl/sspwm_modulator.sv
module sspwm_modulator #(
  parameter int          SAMPLE_W   = 12,
  parameter int          NOM_PERIOD = 417,
  parameter int          SPREAD_PCT = 30,
  parameter logic [15:0] SEED       = 16'hACE1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       run_en,
  input  logic                       spread_en,
  input  logic signed [SAMPLE_W-1:0] sample_in,
  output logic                       out_p,
  output logic                       out_n
);
  localparam int SPAN = NOM_PERIOD * SPREAD_PCT / 100;
  localparam int PW   = $clog2(NOM_PERIOD + SPAN + 1);

  logic          start_evt;
  logic          running;
  logic [PW-1:0] cnt;
  logic [PW-1:0] period_q;
  logic [PW-1:0] dp_q;
  logic [PW-1:0] dn_q;
  logic [PW-1:0] period_nxt;
  logic [PW-1:0] dp_nxt;
  logic [PW-1:0] dn_nxt;

  sspwm_dither #(.NOM_PERIOD(NOM_PERIOD), .SPAN(SPAN), .PW(PW), .SEED(SEED)) u_dither (
    .clk(clk), .rst_n(rst_n), .adv(start_evt), .spread_en(spread_en),
    .period_nxt(period_nxt)
  );

  sspwm_duty #(.SAMPLE_W(SAMPLE_W), .PW(PW)) u_duty (
    .period(period_nxt), .sample(sample_in), .duty_p(dp_nxt), .duty_n(dn_nxt)
  );

  sspwm_timer #(.NOM_PERIOD(NOM_PERIOD), .PW(PW)) u_timer (
    .clk(clk), .rst_n(rst_n), .run_en(run_en),
    .period_nxt(period_nxt), .dp_nxt(dp_nxt), .dn_nxt(dn_nxt),
    .out_p(out_p), .out_n(out_n), .start_evt(start_evt), .running(running),
    .cnt(cnt), .period_q(period_q), .dp_q(dp_q), .dn_q(dn_q)
  );

endmodule

// File: rtl/sspwm_checker.sv
module sspwm_checker #(
  parameter int SAMPLE_W   = 12,
  parameter int NOM_PERIOD = 417,
  parameter int SPAN       = 125,
  parameter int PW         = 10
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       spread_en,
  input logic signed [SAMPLE_W-1:0] sample_in,
  input logic                       out_p,
  input logic                       out_n,
  input logic                       start_evt,
  input logic                       running,
  input logic [PW-1:0]              cnt,
  input logic [PW-1:0]              period_q,
  input logic [PW-1:0]              dp_q,
  input logic [PW-1:0]              dn_q
);
  localparam logic [PW-1:0] P_MIN = PW'(NOM_PERIOD - SPAN);
  localparam logic [PW-1:0] P_MAX = PW'(NOM_PERIOD + SPAN);
  localparam logic [PW-1:0] P_NOM = PW'(NOM_PERIOD);

  assert_zero_equal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && sample_in == '0) |=> (dp_q == dn_q));

  assert_fixed_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && !spread_en) |=> (period_q == P_NOM));

  assert_in_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (running && cnt == '0) |-> (out_p && out_n));

  assert_period_band_R6: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (period_q >= P_MIN && period_q <= P_MAX));

  assert_duty_clamp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (dp_q >= PW'(1) && dp_q < period_q && dn_q >= PW'(1) && dn_q < period_q));

  assert_sample_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !start_evt) |=> ($stable(dp_q) && $stable(dn_q)));

  assert_idle_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (!out_p && !out_n));

endmodule

bind sspwm_modulator sspwm_checker #(
  .SAMPLE_W(SAMPLE_W), .NOM_PERIOD(NOM_PERIOD), .SPAN(SPAN), .PW(PW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .spread_en(spread_en), .sample_in(sample_in),
  .out_p(out_p), .out_n(out_n), .start_evt(start_evt), .running(running),
  .cnt(cnt), .period_q(period_q), .dp_q(dp_q), .dn_q(dn_q)
);

// File: tb/tb_sspwm_modulator.sv
`timescale 1ns/1ps
module tb_sspwm_modulator;
  localparam int W     = 12;
  localparam int NOM   = 417;
  localparam int SPAN  = 125;
  localparam int LIMIT = 2 * (NOM + SPAN);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_en = 1'b0;
  logic spread_en = 1'b0;
  logic signed [W-1:0] sample = '0;
  logic out_p, out_n;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  sspwm_modulator dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .spread_en(spread_en),
    .sample_in(sample), .out_p(out_p), .out_n(out_n)
  );

  function automatic int exp_high(int p, int s, bit neg);
    int half, prod, d, v;
    half = p / 2;
    prod = s * half;
    if (prod >= 0) d = prod / 2048;
    else           d = -((-prod + 2047) / 2048);
    v = neg ? half - d : half + d;
    if (v < 1) v = 1;
    if (v > p - 1) v = p - 1;
    return v;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_start();
    logic lp;
    int   k;
    lp = out_p;
    k  = 0;
    @(negedge clk);
    while (!(out_p && !lp) && k < LIMIT) begin
      lp = out_p;
      k++;
      @(negedge clk);
    end
    if (k >= LIMIT) check(1'b0, "watchdog wait_start", k, LIMIT);
  endtask

  // Called at the first cycle of a period; ends at the first cycle of the next.
  task automatic measure(output int p, output int hp, output int hn, input bit junk);
    logic lp;
    bit   done;
    p = 0; hp = 0; hn = 0; done = 1'b0;
    while (!done) begin
      hp += int'(out_p);
      hn += int'(out_n);
      p++;
      lp = out_p;
      if (junk && p == 5) sample = W'($urandom_range(4095, 1));
      @(negedge clk);
      if (out_p && !lp) done = 1'b1;
      if (p > LIMIT) begin
        check(1'b0, "watchdog measure", p, LIMIT);
        done = 1'b1;
      end
    end
  endtask

  // Sets the sample at a period start, skips that period, measures the next.
  task automatic apply(int s, bit junk, output int p, output int hp, output int hn);
    int dp, dh, dn;
    sample = W'(s);
    measure(dp, dh, dn, 1'b0);
    check(out_n === 1'b1, "R5 legs rise together", int'(out_n), 1);
    measure(p, hp, hn, junk);
  endtask

  task automatic check_fixed(int s, string tag);
    int p, hp, hn;
    apply(s, 1'b0, p, hp, hn);
    check(p == NOM, "R2 fixed period", p, NOM);
    check(hp == exp_high(NOM, s, 1'b0), {tag, " positive leg"}, hp, exp_high(NOM, s, 1'b0));
    check(hn == exp_high(NOM, s, 1'b1), {tag, " negative leg"}, hn, exp_high(NOM, s, 1'b1));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog global", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int p, hp, hn, s, first_p, distinct;
    void'($urandom(32'd20240611));

    // R12: reset state
    repeat (3) @(negedge clk);
    check(out_p == 1'b0 && out_n == 1'b0, "R12 low in reset", int'({out_p, out_n}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_p == 1'b0 && out_n == 1'b0, "R12 low after reset", int'({out_p, out_n}), 0);

    run_en = 1'b1;
    wait_start();
    check(out_n === 1'b1, "R5 first period in phase", int'(out_n), 1);

    // R1: zero sample
    apply(0, 1'b0, p, hp, hn);
    check(p == NOM, "R2 period at zero input", p, NOM);
    check(hp == NOM / 2, "R1 positive leg half", hp, NOM / 2);
    check(hn == NOM / 2, "R1 negative leg half", hn, NOM / 2);

    check_fixed(1024, "R3 half scale");
    check_fixed(-1024, "R4 negative half scale");
    check_fixed(2047, "R3 full positive");
    check_fixed(-2048, "R9 clamp most negative");
    check_fixed(1, "R3 smallest positive");
    check_fixed(-1, "R4 smallest negative");

    // R10: a mid-period change is ignored
    apply(700, 1'b1, p, hp, hn);
    check(hp == exp_high(NOM, 700, 1'b0), "R10 positive leg holds", hp, exp_high(NOM, 700, 1'b0));
    check(hn == exp_high(NOM, 700, 1'b1), "R10 negative leg holds", hn, exp_high(NOM, 700, 1'b1));

    // Random samples, fixed period
    for (int i = 0; i < 16; i++) begin
      s = int'($urandom_range(4095, 0)) - 2048;
      if (s >= 0) check_fixed(s, "R3 random");
      else        check_fixed(s, "R4 random");
    end

    // R6, R7, R8: dithered periods
    spread_en = 1'b1;
    first_p = -1;
    distinct = 0;
    for (int i = 0; i < 24; i++) begin
      s = int'($urandom_range(4095, 0)) - 2048;
      apply(s, 1'b0, p, hp, hn);
      check(p >= NOM - SPAN && p <= NOM + SPAN, "R6 period in band", p, NOM);
      check(hp == exp_high(p, s, 1'b0), "R8 scaled positive leg", hp, exp_high(p, s, 1'b0));
      check(hn == exp_high(p, s, 1'b1), "R8 scaled negative leg", hn, exp_high(p, s, 1'b1));
      if (first_p < 0) first_p = p;
      else if (p != first_p) distinct = 1;
    end
    check(distinct == 1, "R7 period varies", distinct, 1);

    spread_en = 1'b0;
    apply(0, 1'b0, p, hp, hn);
    apply(0, 1'b0, p, hp, hn);
    check(p == NOM, "R2 period back to nominal", p, NOM);

    // R11: stop after the current period
    apply(512, 1'b0, p, hp, hn);
    measure(p, hp, hn, 1'b0);
    run_en = 1'b0;
    hp = 0; hn = 0;
    for (int k = 0; k < NOM; k++) begin
      hp += int'(out_p);
      hn += int'(out_n);
      @(negedge clk);
    end
    check(hp == exp_high(NOM, 512, 1'b0), "R11 final period positive leg", hp, exp_high(NOM, 512, 1'b0));
    check(hn == exp_high(NOM, 512, 1'b1), "R11 final period negative leg", hn, exp_high(NOM, 512, 1'b1));
    hp = 0;
    for (int k = 0; k < 3 * NOM; k++) begin
      hp += int'(out_p) + int'(out_n);
      @(negedge clk);
    end
    check(hp == 0, "R11 held low after stop", hp, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule